// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Buffer Controller

This block manages the transmit side of a single device-mode isochronous IN endpoint. A processor or DMA engine streams bytes into the block, and a commit marks each complete packet. The block counts the bytes, limits every packet to the programmed maximum packet size, and queues the packet lengths in one or two packet slots. The slot count depends on whether double buffering is on.

The serial engine raises a token strobe when the host's IN token arrives. If a committed packet is waiting, the block answers with a transmit-start pulse and that packet's length. The packet is then consumed when the serial engine reports completion. Isochronous transfers have no retry, so a consumed packet never comes back. If no packet is waiting, the block answers with a zero-length packet and sets a sticky underrun flag, which software reads back after each packet.

A DMA request follows the free packet space. An interrupt pulse reports transmit completions and underruns. A DMA mode bit restricts the interrupt to underruns only.

Top module: `iso_in_ep`

## Requirements
- R1: After synchronous reset, the following are all zero: every register read (control word at address 0, maximum size at 1, FIFO configuration at 2, interrupt enable at 3), `tx_go`, `tx_zlp`, `irq` and `dma_req`.
- R2: The committed packet length is the number of `ld_byte` strobes since the previous commit, saturated at the maximum packet size held in register 1, bits [LEN_W-1:0].
- R3: A commit happens on `ld_commit` or on a write of 1 to control bit 0. A token with a packet waiting gives a one-cycle `tx_go` with `tx_len` equal to the oldest packet's length in the cycle after the token. A `tx_done` pulse consumes that packet for good.
- R4: A token with no packet waiting gives a one-cycle `tx_zlp` with `tx_len` = 0 in the cycle after the token. It also sets the underrun flag, which reads back as control bit 2.
- R5: The underrun flag holds until a control write carries 0 in bit 2. A control write with 1 in bit 2 leaves it set.
- R6: With FIFO configuration bit 4 clear, only one packet can be pending. Bytes and commits are ignored while it is pending, and control bit 0 (ready) reads 1.
- R7: With FIFO configuration bit 4 set, two packets can be pending and are sent in commit order. Control bit 0 reads 1 only when both slots are full. Control bit 1 reads 1 whenever at least one packet is pending.
- R8: `dma_req` is high exactly when control bit 12 (DMA enable) and bit 13 (transmit FIFO enable) are set and a slot is free.
- R9: When control bits 12 and 10 are both set, a completed transmission raises no interrupt, but an underrun still does. With bit 10 set and bit 12 clear, completions still interrupt.
- R10: With interrupt-enable bit 0 set, `irq` pulses for one cycle after each completion and each underrun. With it clear, `irq` stays low, but the underrun flag is still set.
- R11: Control bit 11 (force toggle) is stored and reads back, but has no effect on the transmit response.
- R12: With control bit 14 (isochronous) clear, tokens are ignored: no `tx_go`, no `tx_zlp`, no underrun, and pending packets are kept.
- R13: With control bit 13 clear, byte loads and commits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from address) |
| ld_byte | input | 1 | One packet byte loaded |
| ld_commit | input | 1 | Packet load complete |
| tok_in | input | 1 | IN token received for this endpoint |
| tx_done | input | 1 | Serial engine finished sending the current packet |
| tx_go | output | 1 | Start sending a loaded packet |
| tx_zlp | output | 1 | Send a zero-length packet (underrun response) |
| tx_len | output | LEN_W | Length of the packet being started |
| dma_req | output | 1 | Space for another packet |
| irq | output | 1 | Endpoint interrupt pulse |

## Verification
The bench builds the block with LEN_W = 4, so packet lengths and the maximum size each range over 0 to 15. At that width, every maximum size can be crossed with every load length from 0 to 17. This covers empty packets, exact-maximum packets and overlong loads that must saturate. Because the slot count is two at most, every single- and double-buffer fill state can be reached directly. Each fill state is paired with the DMA request, the ready bit and the back-to-back token order.

// File: rtl/iso_in_pkg.sv
`timescale 1ns/1ps
package iso_in_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] A_MAXP = 2'd1;
    localparam logic [REG_AW-1:0] A_FCFG = 2'd2;
    localparam logic [REG_AW-1:0] A_IE   = 2'd3;

    localparam int B_RDY     = 0;
    localparam int B_NE      = 1;
    localparam int B_URUN    = 2;
    localparam int B_DMAMODE = 10;
    localparam int B_FRCTOG  = 11;
    localparam int B_DMAEN   = 12;
    localparam int B_TXMODE  = 13;
    localparam int B_ISO     = 14;
    localparam int B_DBUF    = 4;
    localparam int B_IE      = 0;

    localparam int NSLOT = 2;
    localparam int CNT_W = $clog2(NSLOT + 1);

    typedef struct packed {
        logic iso;
        logic tx_mode;
        logic dma_en;
        logic frc_tog;
        logic dma_mode;
    } ep_ctrl_t;

    typedef struct packed {
        logic commit;
        logic clr_urun;
    } reg_cmd_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_e;

    function automatic logic sent_irq_allowed(ep_ctrl_t c);
        return !(c.dma_en && c.dma_mode);
    endfunction

    function automatic logic [CNT_W-1:0] slot_depth(logic dbuf);
        return dbuf ? CNT_W'(NSLOT) : CNT_W'(1);
    endfunction

endpackage

// File: rtl/iso_in_regs.sv
`timescale 1ns/1ps
module iso_in_regs
    import iso_in_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              urun_set,
    input  logic              pkt_full,
    input  logic              fifo_ne,
    output logic [REG_DW-1:0] rdata,
    output ep_ctrl_t          ctrl,
    output logic [LEN_W-1:0]  maxp,
    output logic              dbuf,
    output logic              ie,
    output logic              urun,
    output reg_cmd_t          cmd
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == A_CTRL);

    always_comb begin
        cmd.commit   = ctrl_wr && wdata[B_RDY];
        cmd.clr_urun = ctrl_wr && !wdata[B_URUN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            maxp <= '0;
            dbuf <= 1'b0;
            ie   <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    ctrl.iso      <= wdata[B_ISO];
                    ctrl.tx_mode  <= wdata[B_TXMODE];
                    ctrl.dma_en   <= wdata[B_DMAEN];
                    ctrl.frc_tog  <= wdata[B_FRCTOG];
                    ctrl.dma_mode <= wdata[B_DMAMODE];
                end
                A_MAXP:  maxp <= wdata[LEN_W-1:0];
                A_FCFG:  dbuf <= wdata[B_DBUF];
                A_IE:    ie   <= wdata[B_IE];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            urun <= 1'b0;
        end else if (urun_set) begin
            urun <= 1'b1;
        end else if (cmd.clr_urun) begin
            urun <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_RDY]     = pkt_full;
                rdata[B_NE]      = fifo_ne;
                rdata[B_URUN]    = urun;
                rdata[B_DMAMODE] = ctrl.dma_mode;
                rdata[B_FRCTOG]  = ctrl.frc_tog;
                rdata[B_DMAEN]   = ctrl.dma_en;
                rdata[B_TXMODE]  = ctrl.tx_mode;
                rdata[B_ISO]     = ctrl.iso;
            end
            A_MAXP:  rdata[LEN_W-1:0] = maxp;
            A_FCFG:  rdata[B_DBUF]    = dbuf;
            A_IE:    rdata[B_IE]      = ie;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/iso_in_pktq.sv
`timescale 1ns/1ps
module iso_in_pktq
    import iso_in_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dbuf,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    input  logic             pop,
    output logic [CNT_W-1:0] count,
    output logic [LEN_W-1:0] head_len,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = $clog2(NSLOT);

    logic [LEN_W-1:0] slot_len [NSLOT];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (count >= slot_depth(dbuf));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_len[g] <= '0;
            end else if (push_ok && (wr_ptr == PTR_W'(g))) begin
                slot_len[g] <= push_len;
            end
        end
    end

    assign head_len = slot_len[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_W'(NSLOT - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_W'(NSLOT - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/iso_in_txfsm.sv
`timescale 1ns/1ps
module iso_in_txfsm
    import iso_in_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_in,
    input  logic             tx_done,
    input  logic             iso_on,
    input  logic             avail,
    input  logic [LEN_W-1:0] head_len,
    output logic             tx_go,
    output logic             tx_zlp,
    output logic [LEN_W-1:0] tx_len,
    output logic             pop,
    output logic             sent,
    output logic             urun_evt
);

    tx_state_e state;
    logic      serve;

    assign serve    = tok_in && (state == TX_IDLE) && iso_on;
    assign urun_evt = serve && !avail;
    assign pop      = (state == TX_BUSY) && tx_done;
    assign sent     = pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            tx_go  <= 1'b0;
            tx_zlp <= 1'b0;
            tx_len <= '0;
        end else begin
            tx_go  <= serve && avail;
            tx_zlp <= urun_evt;
            if (serve) begin
                tx_len <= avail ? head_len : '0;
            end
            case (state)
                TX_IDLE: if (serve && avail) state <= TX_BUSY;
                TX_BUSY: if (tx_done)        state <= TX_IDLE;
                default:                     state <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/iso_in_ep.sv
`timescale 1ns/1ps
module iso_in_ep
    import iso_in_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              ld_byte,
    input  logic              ld_commit,
    input  logic              tok_in,
    input  logic              tx_done,
    output logic              tx_go,
    output logic              tx_zlp,
    output logic [LEN_W-1:0]  tx_len,
    output logic              dma_req,
    output logic              irq
);

    ep_ctrl_t         ctrl;
    reg_cmd_t         cmd;
    logic [LEN_W-1:0] maxp;
    logic             dbuf;
    logic             ie;
    logic             urun;
    logic             urun_evt;
    logic             sent;
    logic             q_pop;
    logic             q_full;
    logic             q_empty;
    logic [CNT_W-1:0] q_count;
    logic [LEN_W-1:0] q_head_len;
    logic [LEN_W-1:0] fill_len;
    logic [LEN_W-1:0] byte_len;
    logic             ld_ok;
    logic             q_push;

    iso_in_regs #(.LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .urun_set (urun_evt),
        .pkt_full (q_full),
        .fifo_ne  (!q_empty),
        .rdata    (reg_rdata),
        .ctrl     (ctrl),
        .maxp     (maxp),
        .dbuf     (dbuf),
        .ie       (ie),
        .urun     (urun),
        .cmd      (cmd)
    );

    // Byte counting for the packet being filled, saturated at the max size.
    assign ld_ok    = ctrl.tx_mode && !q_full;
    assign byte_len = (ld_byte && (fill_len < maxp)) ? fill_len + 1'b1 : fill_len;
    assign q_push   = ld_ok && (ld_commit || cmd.commit);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_len <= '0;
        end else if (q_push) begin
            fill_len <= '0;
        end else if (ld_ok) begin
            fill_len <= byte_len;
        end
    end

    iso_in_pktq #(.LEN_W(LEN_W)) u_q (
        .clk      (clk),
        .rst      (rst),
        .dbuf     (dbuf),
        .push     (q_push),
        .push_len (byte_len),
        .pop      (q_pop),
        .count    (q_count),
        .head_len (q_head_len),
        .full     (q_full),
        .empty    (q_empty)
    );

    iso_in_txfsm #(.LEN_W(LEN_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tok_in   (tok_in),
        .tx_done  (tx_done),
        .iso_on   (ctrl.iso),
        .avail    (!q_empty),
        .head_len (q_head_len),
        .tx_go    (tx_go),
        .tx_zlp   (tx_zlp),
        .tx_len   (tx_len),
        .pop      (q_pop),
        .sent     (sent),
        .urun_evt (urun_evt)
    );

    assign dma_req = ctrl.dma_en && ctrl.tx_mode && !q_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= ie && (urun_evt || (sent && sent_irq_allowed(ctrl)));
        end
    end

endmodule

// File: rtl/iso_in_ep_chk.sv
`timescale 1ns/1ps
module iso_in_ep_chk
    import iso_in_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_go,
    input logic             tx_zlp,
    input logic [LEN_W-1:0] tx_len,
    input logic             irq,
    input logic             dma_req,
    input logic             full,
    input logic [CNT_W-1:0] count,
    input logic             urun,
    input logic             urun_evt,
    input logic             clr_urun,
    input logic             dma_en,
    input logic             dma_mode
);

    AST_GO_ZLP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_go && tx_zlp)); // R4

    AST_ZLP_LEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        tx_zlp |-> (tx_len == '0)); // R4

    AST_URUN_SETS: assert property (@(posedge clk) disable iff (rst)
        urun_evt |=> urun); // R4

    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (urun && !clr_urun) |=> urun); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(NSLOT)); // R7

    AST_DMA_REQ_SPACE: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> !full); // R8

    AST_DMA_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(dma_en && dma_mode)) |-> $past(urun_evt)); // R9

endmodule

bind iso_in_ep iso_in_ep_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_go    (tx_go),
    .tx_zlp   (tx_zlp),
    .tx_len   (tx_len),
    .irq      (irq),
    .dma_req  (dma_req),
    .full     (q_full),
    .count    (q_count),
    .urun     (urun),
    .urun_evt (urun_evt),
    .clr_urun (cmd.clr_urun),
    .dma_en   (ctrl.dma_en),
    .dma_mode (ctrl.dma_mode)
);

// File: tb/iso_in_ep_tb.sv
`timescale 1ns/1ps
module iso_in_ep_tb;

    localparam int LW = 4;
    localparam logic [1:0] RC = 2'd0, RM = 2'd1, RF = 2'd2, RI = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          ld_byte = 1'b0;
    logic          ld_commit = 1'b0;
    logic          tok_in = 1'b0;
    logic          tx_done = 1'b0;
    logic          tx_go;
    logic          tx_zlp;
    logic [LW-1:0] tx_len;
    logic          dma_req;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    iso_in_ep #(.LEN_W(LW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ld_byte(ld_byte),
        .ld_commit(ld_commit), .tok_in(tok_in), .tx_done(tx_done),
        .tx_go(tx_go), .tx_zlp(tx_zlp), .tx_len(tx_len),
        .dma_req(dma_req), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ld_byte = 1'b1;
        end
        @(negedge clk); ld_byte = 1'b0;
    endtask

    task automatic load(input int n);
        bytes(n);
        ld_commit = 1'b1;
        @(negedge clk); ld_commit = 1'b0;
    endtask

    task automatic token(output logic go, output logic zlp, output int len, output logic ir);
        @(negedge clk); tok_in = 1'b1;
        @(posedge clk); #1; go = tx_go; zlp = tx_zlp; len = int'(tx_len); ir = irq;
        @(negedge clk); tok_in = 1'b0;
    endtask

    task automatic done(output logic ir);
        @(negedge clk); tx_done = 1'b1;
        @(posedge clk); #1; ir = irq;
        @(negedge clk); tx_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic go, zlp, ir;
        int len;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(RC, d); chk("R1 ctrl", int'(d), 0);
        rd(RM, d); chk("R1 maxp", int'(d), 0);
        rd(RF, d); chk("R1 fcfg", int'(d), 0);
        rd(RI, d); chk("R1 ie", int'(d), 0);
        chk("R1 outs", int'({tx_go, tx_zlp, irq, dma_req}), 0);

        wr(RC, 16'h6000);
        wr(RI, 16'h0001);

        // R2/R3: sweep max size against load length
        for (int m = 0; m < 16; m++) begin
            wr(RM, 16'(m));
            for (int n = 0; n < 18; n++) begin
                load(n);
                token(go, zlp, len, ir);
                chk("R3 go", int'(go), 1);
                chk("R2 len", len, (n < m) ? n : m);
                done(ir);
                chk("R10 irq on completion", int'(ir), 1);
            end
        end

        // R3: commit through control bit 0
        bytes(4);
        wr(RC, 16'h6001);
        token(go, zlp, len, ir);
        chk("R3 reg commit len", len, 4);
        done(ir);

        // R4/R5: underrun
        token(go, zlp, len, ir);
        chk("R4 zlp", int'(zlp), 1);
        chk("R4 no go", int'(go), 0);
        chk("R4 len", len, 0);
        chk("R10 irq underrun", int'(ir), 1);
        rd(RC, d); chk("R4 flag", int'(d[2]), 1);
        wr(RC, 16'h6004);
        rd(RC, d); chk("R5 write one keeps", int'(d[2]), 1);
        wr(RC, 16'h6000);
        rd(RC, d); chk("R5 write zero clears", int'(d[2]), 0);

        // R6: single buffer
        load(3);
        rd(RC, d); chk("R6 ready", int'(d[0]), 1);
        load(7);
        token(go, zlp, len, ir);
        chk("R6 first len", len, 3);
        done(ir);
        token(go, zlp, len, ir);
        chk("R6 second ignored", int'(zlp), 1);
        wr(RC, 16'h6000);

        // R7: double buffer
        wr(RF, 16'h0010);
        load(2);
        rd(RC, d);
        chk("R7 ready one", int'(d[0]), 0);
        chk("R7 nonempty", int'(d[1]), 1);
        load(5);
        rd(RC, d); chk("R7 ready two", int'(d[0]), 1);
        token(go, zlp, len, ir); chk("R7 order first", len, 2);
        done(ir);
        token(go, zlp, len, ir); chk("R7 order second", len, 5);
        chk("R7 second go", int'(go), 1);
        done(ir);
        token(go, zlp, len, ir); chk("R7 drained", int'(zlp), 1);
        rd(RC, d); chk("R7 empty", int'(d[1]), 0);

        // R8: DMA request
        wr(RF, 16'h0000);
        wr(RC, 16'h7000);
        #1; chk("R8 req empty", int'(dma_req), 1);
        load(1);
        #1; chk("R8 req single full", int'(dma_req), 0);
        token(go, zlp, len, ir);
        done(ir);
        #1; chk("R8 req after send", int'(dma_req), 1);
        wr(RF, 16'h0010);
        load(1);
        #1; chk("R8 req one of two", int'(dma_req), 1);
        load(1);
        #1; chk("R8 req two of two", int'(dma_req), 0);
        token(go, zlp, len, ir); done(ir);
        token(go, zlp, len, ir); done(ir);
        wr(RF, 16'h0000);

        // R9: DMA mode suppresses completion interrupts
        wr(RC, 16'h7400);
        load(2);
        token(go, zlp, len, ir);
        done(ir);
        chk("R9 no irq on completion", int'(ir), 0);
        token(go, zlp, len, ir);
        chk("R9 irq on underrun", int'(ir), 1);
        wr(RC, 16'h6400);
        load(1);
        token(go, zlp, len, ir);
        done(ir);
        chk("R9 dma off keeps irq", int'(ir), 1);

        // R10: interrupt enable off
        wr(RI, 16'h0000);
        load(1);
        token(go, zlp, len, ir);
        done(ir);
        chk("R10 masked completion", int'(ir), 0);
        token(go, zlp, len, ir);
        chk("R10 masked underrun", int'(ir), 0);
        rd(RC, d); chk("R10 flag still set", int'(d[2]), 1);
        wr(RI, 16'h0001);

        // R11: force toggle has no effect
        wr(RC, 16'h6800);
        load(6);
        token(go, zlp, len, ir);
        chk("R11 go", int'(go), 1);
        chk("R11 len", len, 6);
        rd(RC, d); chk("R11 readback", int'(d[11]), 1);
        done(ir);
        chk("R11 irq", int'(ir), 1);

        // R12: isochronous off ignores tokens
        wr(RC, 16'h2000);
        load(3);
        token(go, zlp, len, ir);
        chk("R12 no response", int'({go, zlp}), 0);
        rd(RC, d); chk("R12 no underrun", int'(d[2]), 0);
        wr(RC, 16'h6000);
        token(go, zlp, len, ir);
        chk("R12 packet kept", len, 3);
        done(ir);

        // R13: transmit FIFO disabled ignores loads
        wr(RC, 16'h5000);
        #1; chk("R13 no dma req", int'(dma_req), 0);
        load(2);
        rd(RC, d); chk("R13 nothing loaded", int'(d[1]), 0);
        token(go, zlp, len, ir);
        chk("R13 underrun", int'(zlp), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule